// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Bit Synchronization

This block produces the serial clock of an I2C master from a fast system clock. It never drives SCL high. In each cycle it either pulls the line low or lets it float, and a pull-up on the board raises it. One cycle is two half-period units of system clocks, one unit low and one unit high. A one-bit rate select chooses between a standard-mode unit length and a fast-mode unit length.

Each time the block lets SCL go, it watches the real pin level for a window whose length also depends on the selected rate. The pin first passes through a two-flop synchronizer, and that latency is counted inside the window. If the pin is seen high within the window, the next falling edge comes one unit after the release. If it is not seen, the block assumes the line has not risen yet. It then drops the falling edge it would have made and keeps SCL released for two more units. A slow line therefore gives a clock at half the set rate, with a 3:1 high-to-low ratio.

The default parameters assume a 250 MHz system clock. The standard window is 252 cycles, which covers a 1000 ns rise plus synchronizer delay. The fast window is 77 cycles, which covers a 300 ns rise.

Top module: `sclBitSyncGen`

## Requirements
- R1: While reset is asserted, and while enable is low, sclDriveLow is 0 (SCL released) and fallStrobe is 0.
- R2: When enable goes high, sclDriveLow and fallStrobe both become 1 at the first clock edge. SCL then stays driven low for exactly one unit of the selected rate.
- R3: If the check passes, SCL is released for exactly one unit and is then driven low again. The full period is two units.
- R4: The window covers the first M cycles of the released phase, numbered from 1. M is MON_STD when rateSel=0 and MON_FAST when rateSel=1. A pin level that is high at the clock edge closing released cycle k reaches the check in cycle k+2. The check therefore passes exactly when the pin rises by the edge that closes cycle M-2.
- R5: If the check fails, no falling edge is made at the end of the first released unit. SCL stays released for two more units, three units in all, and is then driven low for one unit.
- R6: The unit is HALF_STD system clocks when rateSel=0 and HALF_FAST when rateSel=1. rateSel is sampled only when a low phase starts, so a change during a cycle takes effect at the next falling edge.
- R7: Deasserting enable releases SCL at the next clock edge, even in the middle of a low phase. After enable is asserted again, the first low phase lasts a full unit.
- R8: fallStrobe is high for one clock exactly in the first cycle of every low phase. It is never high in any other cycle, including the end of a unit where the falling edge was skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the SCL generator; low releases SCL and clears the counters |
| rateSel | input | 1 | 0 = standard-mode unit and window, 1 = fast-mode unit and window |
| sclIn | input | 1 | Raw level read from the SCL pin |
| sclDriveLow | output | 1 | 1 = pull SCL low, 0 = release it |
| fallStrobe | output | 1 | One-clock pulse on each generated SCL falling edge |

## Verification
The bench models the open-drain line with a rise delay that can be set. For both rates it sweeps that delay from one cycle up to past the end of the window. The delays on either side of the window limit tell the normal two-unit period apart from the skipped-edge four-unit period, and they also show that the synchronizer latency is counted inside the window. Further runs switch rateSel during a low phase, to separate a rate taken at once from one taken at the next edge. Other runs drop enable in the middle of a low phase, to confirm that SCL is released at once and that the next start has a full low unit. The strobe is checked in every cycle of every measured period.

// File: rtl/sclGenPkg.sv
package sclGenPkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_EXTRA = 2'd3
  } phase_t;

  // Strobes from control to the timing datapath
  typedef struct packed {
    logic cntClear;
    logic latchRate;
    logic sawClear;
    logic windowArm;
  } timerCtrl_t;

  // Conditions reported by the datapath back to control
  typedef struct packed {
    logic unitDone;
    logic extraDone;
    logic passNow;
  } timerStat_t;

endpackage

// File: rtl/sclSyncStage.sv
module sclSyncStage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  output logic sclSync
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= sclIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], sclIn};
      end
    end
  endgenerate

  assign sclSync = chain[STAGES-1];

endmodule

// File: rtl/sclTimerPath.sv
module sclTimerPath
  import sclGenPkg::*;
#(
  parameter int HALF_STD  = 1250,
  parameter int HALF_FAST = 313,
  parameter int MON_STD   = 252,
  parameter int MON_FAST  = 77,
  parameter int CNT_W     = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  timerCtrl_t ctrl,
  input  logic       rateSel,
  input  logic       sclSync,
  output timerStat_t stat
);

  localparam logic [CNT_W-1:0] STD_UNIT_END   = CNT_W'(HALF_STD - 1);
  localparam logic [CNT_W-1:0] FAST_UNIT_END  = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] STD_EXTRA_END  = CNT_W'(2 * HALF_STD - 1);
  localparam logic [CNT_W-1:0] FAST_EXTRA_END = CNT_W'(2 * HALF_FAST - 1);
  localparam logic [CNT_W-1:0] STD_WIN        = CNT_W'(MON_STD);
  localparam logic [CNT_W-1:0] FAST_WIN       = CNT_W'(MON_FAST);

  logic             rateReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] unitEnd;
  logic [CNT_W-1:0] extraEnd;
  logic [CNT_W-1:0] winLen;
  logic             sawHigh;
  logic             inWindow;

  always_comb begin
    unitEnd  = rateReg ? FAST_UNIT_END  : STD_UNIT_END;
    extraEnd = rateReg ? FAST_EXTRA_END : STD_EXTRA_END;
    winLen   = rateReg ? FAST_WIN       : STD_WIN;
  end

  assign inWindow = ctrl.windowArm && (cnt < winLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rateReg <= 1'b0;
    else if (ctrl.latchRate) rateReg <= rateSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (ctrl.cntClear) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    sawHigh <= 1'b0;
    else if (ctrl.sawClear)       sawHigh <= 1'b0;
    else if (inWindow && sclSync) sawHigh <= 1'b1;
  end

  always_comb begin
    stat.unitDone  = (cnt == unitEnd);
    stat.extraDone = (cnt == extraEnd);
    stat.passNow   = sawHigh || (inWindow && sclSync);
  end

  // R4: the pin may only count as seen high inside the monitoring window
  assert_window_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sawHigh) |-> $past(inWindow));

  // R5: the phase counter never runs past the end of a stretched high phase
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= extraEnd);

endmodule

// File: rtl/sclPhaseCtrl.sv
module sclPhaseCtrl
  import sclGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  timerStat_t stat,
  output timerCtrl_t tctl,
  output logic       sclDriveLow,
  output logic       fallStrobe
);

  phase_t phase, phaseNext;
  logic   driveNext;
  logic   strobeNext;

  always_comb begin
    phaseNext  = phase;
    driveNext  = sclDriveLow;
    strobeNext = 1'b0;
    tctl       = '0;
    if (!enable) begin
      phaseNext     = PH_IDLE;
      driveNext     = 1'b0;
      tctl.cntClear = 1'b1;
      tctl.sawClear = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext      = PH_LOW;
          driveNext      = 1'b1;
          strobeNext     = 1'b1;
          tctl.cntClear  = 1'b1;
          tctl.latchRate = 1'b1;
          tctl.sawClear  = 1'b1;
        end
        PH_LOW: begin
          if (stat.unitDone) begin
            phaseNext     = PH_HIGH;
            driveNext     = 1'b0;
            tctl.cntClear = 1'b1;
            tctl.sawClear = 1'b1;
          end
        end
        PH_HIGH: begin
          tctl.windowArm = 1'b1;
          if (stat.unitDone) begin
            tctl.cntClear = 1'b1;
            if (stat.passNow) begin
              phaseNext      = PH_LOW;
              driveNext      = 1'b1;
              strobeNext     = 1'b1;
              tctl.latchRate = 1'b1;
            end else begin
              phaseNext = PH_EXTRA;
            end
          end
        end
        PH_EXTRA: begin
          if (stat.extraDone) begin
            phaseNext      = PH_LOW;
            driveNext      = 1'b1;
            strobeNext     = 1'b1;
            tctl.cntClear  = 1'b1;
            tctl.latchRate = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      sclDriveLow <= 1'b0;
      fallStrobe  <= 1'b0;
    end else begin
      phase       <= phaseNext;
      sclDriveLow <= driveNext;
      fallStrobe  <= strobeNext;
    end
  end

  // R8: a strobe marks exactly the cycles where the line starts being pulled low
  assert_strobe_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> $rose(sclDriveLow));
  assert_fall_has_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> fallStrobe);

  // R7: dropping enable releases the line at the next edge
  assert_disable_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  // R5: a failed check skips the edge and keeps the line released
  assert_skip_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_HIGH && stat.unitDone && !stat.passNow)
      |=> (!sclDriveLow && !fallStrobe && phase == PH_EXTRA));

  // R5: the stretched phase never pulls the line
  assert_extra_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXTRA) |-> !sclDriveLow);

endmodule

// File: rtl/sclBitSyncGen.sv
module sclBitSyncGen
  import sclGenPkg::*;
#(
  parameter int HALF_STD    = 1250,
  parameter int HALF_FAST   = 313,
  parameter int MON_STD     = 252,
  parameter int MON_FAST    = 77,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic rateSel,
  input  logic sclIn,
  output logic sclDriveLow,
  output logic fallStrobe
);

  localparam int MAX_HALF = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
  localparam int CNT_W    = $clog2(2 * MAX_HALF + 1);

  logic       sclSync;
  timerCtrl_t tctl;
  timerStat_t stat;

  sclSyncStage #(
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sclSync(sclSync)
  );

  sclTimerPath #(
    .HALF_STD (HALF_STD),
    .HALF_FAST(HALF_FAST),
    .MON_STD  (MON_STD),
    .MON_FAST (MON_FAST),
    .CNT_W    (CNT_W)
  ) uTimer (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (tctl),
    .rateSel(rateSel),
    .sclSync(sclSync),
    .stat   (stat)
  );

  sclPhaseCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .stat       (stat),
    .tctl       (tctl),
    .sclDriveLow(sclDriveLow),
    .fallStrobe (fallStrobe)
  );

endmodule

// File: tb/tb_sclBitSyncGen.sv
module tb_sclBitSyncGen;

  localparam int HS = 12;
  localparam int HF = 6;
  localparam int MS = 8;
  localparam int MF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic rateSel = 1'b0;
  logic sclIn = 1'b1;
  logic sclDriveLow;
  logic fallStrobe;

  int checks = 0;
  int failures = 0;
  int riseDelay = 1;
  int relCnt = 0;

  always #2 clk = ~clk;

  sclBitSyncGen #(
    .HALF_STD(HS), .HALF_FAST(HF), .MON_STD(MS), .MON_FAST(MF), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .fallStrobe(fallStrobe)
  );

  // Open-drain line model: falls at once, rises riseDelay cycles after release
  always @(negedge clk) begin
    if (sclDriveLow) begin
      relCnt <= 0;
      sclIn  <= 1'b0;
    end else begin
      relCnt <= relCnt + 1;
      sclIn  <= (relCnt + 1 >= riseDelay);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic waitStrobe(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!fallStrobe && waited < 500);
  endtask

  // Starts at a negedge showing a strobe; ends at the negedge of the next strobe
  task automatic measurePeriod(output int lowLen, output int highLen, output bit bad);
    lowLen = 0; highLen = 0; bad = 0;
    while (sclDriveLow === 1'b1 && lowLen < 500) begin
      if (lowLen > 0 && fallStrobe) bad = 1;
      lowLen++;
      @(negedge clk);
    end
    while (sclDriveLow === 1'b0 && highLen < 500) begin
      if (fallStrobe) bad = 1;
      highLen++;
      @(negedge clk);
    end
    if (!fallStrobe) bad = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int w, lo, hi, h, m, expHi;
    bit bad;

    // R1: reset and disabled state
    repeat (3) @(negedge clk);
    check(sclDriveLow == 0 && fallStrobe == 0, "R1", "outputs in reset",
          {sclDriveLow, fallStrobe}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(sclDriveLow == 0 && fallStrobe == 0, "R1", "outputs while disabled",
            {sclDriveLow, fallStrobe}, 0);
    end

    // R3 R4 R5 R8: sweep rise delay across the window for both rates
    for (int r = 0; r < 2; r++) begin
      h = r ? HF : HS;
      m = r ? MF : MS;
      for (int d = 1; d <= m + 1; d++) begin
        enable = 1'b0;
        rateSel = r[0];
        riseDelay = d;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        waitStrobe(w);
        check(w == 1, "R2", "edges from enable to first strobe", w, 1);
        expHi = (d <= m - 2) ? h : 3 * h;
        for (int p = 0; p < 3; p++) begin
          measurePeriod(lo, hi, bad);
          check(lo == h, (p == 0) ? "R2" : "R6", "low phase length", lo, h);
          check(hi == expHi, (d <= m - 2) ? "R3" : "R5", "high phase length", hi, expHi);
          if (d == m - 2 || d == m - 1)
            check(hi == expHi, "R4", "window boundary high length", hi, expHi);
          check(!bad, "R8", "strobe placement", bad, 0);
        end
      end
    end

    // R7: drop enable mid low phase, then restart
    enable = 1'b0; rateSel = 1'b0; riseDelay = 1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    waitStrobe(w);
    repeat (5) @(negedge clk);
    check(sclDriveLow == 1, "R7", "line low before disable", sclDriveLow, 1);
    enable = 1'b0;
    @(negedge clk);
    check(sclDriveLow == 0 && fallStrobe == 0, "R7", "release after disable",
          {sclDriveLow, fallStrobe}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sclDriveLow == 0, "R1", "stays released while disabled", sclDriveLow, 0);
    end
    enable = 1'b1;
    waitStrobe(w);
    measurePeriod(lo, hi, bad);
    check(lo == HS, "R7", "full low phase after re-enable", lo, HS);
    check(!bad, "R8", "strobe after re-enable", bad, 0);

    // R6: rate change mid cycle applies at the next falling edge
    rateSel = 1'b1;
    measurePeriod(lo, hi, bad);
    check(lo == HS, "R6", "low unit unchanged after mid-cycle switch", lo, HS);
    check(hi == HS, "R6", "high unit unchanged after mid-cycle switch", hi, HS);
    measurePeriod(lo, hi, bad);
    check(lo == HF, "R6", "low unit after switch to fast", lo, HF);
    check(hi == HF, "R6", "high unit after switch to fast", hi, HF);
    check(!bad, "R8", "strobe across rate change", bad, 0);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule